// File: doc/BRIEF.md
# Single-Slot Reconfiguration Request Scheduler

This block sits between a system bus and a group of function modules. The modules take turns occupying one reconfigurable region, and only one of them can be resident at a time. Each module owns a slice of the bus address space. Every accepted request enters an in-order queue. The request at the head of the queue is held there until the scheduler decides whether its target is already present in the region.

If the target is already resident, the request goes straight out on the dispatch port. If it is not, the scheduler waits until the resident module reports that it is idle. A running module is never interrupted. The scheduler then evicts the resident module and streams the target's configuration image from a configuration memory port: one read per word, using a valid/ready handshake. After the image it waits a fixed settling delay. It then raises a done strobe that carries the loaded module index, and only after that does it dispatch the held request.

When the queue is full, the block deasserts ready toward the bus rather than dropping anything. A busy flag shows that work is still pending.

Top module: `rsched_top`

## Requirements
- R1: The target module index of a request is the top log2(NMOD) bits of its address (bits 7:6 with the defaults), and the dispatch port reports that index together with the request's address and data unchanged.
- R2: After reset no module is resident, so the first request to any module always causes a configuration load before it is dispatched.
- R3: A request whose target is already resident is dispatched without any configuration read and without a done strobe.
- R4: A load of module m issues exactly CFG_LEN[m] reads at consecutive addresses starting at m*CFG_STRIDE. While ready is low, the read address and valid are held.
- R5: When ready is always high, the done strobe is a single-cycle pulse seen CFG_LEN[m]+EXTRA_DELAY cycles after the first read cycle, and it carries index m.
- R6: A request that needs a load is dispatched exactly one cycle after the done strobe, and a dispatch only ever targets the resident module.
- R7: While the resident module signals busy on its mod_busy bit, no configuration read is issued, and the held request waits.
- R8: Loading a module evicts the previous one: a later request to the evicted module loads it again.
- R9: When DEPTH requests are queued, req_ready is low. No request is lost, and requests are dispatched in the order they were accepted.
- R10: busy is low after reset and when nothing is queued or loading, and it is high while a load is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | AW | Request address |
| req_data | input | DW | Request payload |
| mod_busy | input | NMOD | Per-module running flag |
| disp_valid | output | 1 | One-cycle dispatch strobe |
| disp_mod | output | log2(NMOD) | Dispatched module index |
| disp_addr | output | AW | Dispatched address |
| disp_data | output | DW | Dispatched payload |
| cfg_rd_valid | output | 1 | Configuration read request |
| cfg_rd_ready | input | 1 | Configuration memory accepts read |
| cfg_rd_addr | output | CAW | Configuration word address |
| reconf_done | output | 1 | Load complete strobe |
| reconf_mod | output | log2(NMOD) | Index of module just loaded |
| busy | output | 1 | Work queued or load running |

## Verification
The hardest case to reach from the ports is a full queue held behind a resident module that refuses to go idle. To reach it, the bench raises the busy bit of the resident module, sends six requests that alternate between two other modules, and checks that the fifth request stalls with no load started. It then releases the module and checks that the loads and dispatches happen in strict arrival order. A second case makes the configuration port stall every other cycle in the middle of a load, so that the read addresses are checked while they are held and while they advance.

// File: rtl/rsched_pkg.sv
package rsched_pkg;
  typedef enum logic {
    SCH_IDLE,
    SCH_LOAD
  } sch_state_t;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_READ,
    LD_SETTLE
  } ld_state_t;
endpackage

// File: rtl/rsched_fifo.sv
module rsched_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push;

  assign push_ready = (cnt_q != CW'(DEPTH));
  assign head_valid = (cnt_q != '0);
  assign head_data  = mem_q[rd_q];
  assign do_push    = push_valid && push_ready;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (pop)     rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    if (do_push && !pop)      cnt_d = cnt_q + CW'(1);
    else if (!do_push && pop) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end

  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(DEPTH));
  // R9
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> head_valid);
endmodule

// File: rtl/rsched_load.sv
module rsched_load
  import rsched_pkg::*;
#(
  parameter int IW     = 2,
  parameter int LW     = 8,
  parameter int CAW    = 8,
  parameter int STRIDE = 64,
  parameter int EXTRA  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [IW-1:0]  mod_idx,
  input  logic [LW-1:0]  len,
  output logic           cfg_rd_valid,
  input  logic           cfg_rd_ready,
  output logic [CAW-1:0] cfg_rd_addr,
  output logic           fin
);
  localparam int EW = (EXTRA > 1) ? $clog2(EXTRA) : 1;
  localparam logic [EW-1:0] DLAST = EW'((EXTRA > 0) ? EXTRA - 1 : 0);
  localparam bit NO_EXTRA = (EXTRA == 0);

  ld_state_t      st_q, st_d;
  logic [LW-1:0]  wcnt_q, wcnt_d, len_q, len_d;
  logic [EW-1:0]  dcnt_q, dcnt_d;
  logic [CAW-1:0] base_q, base_d;
  logic           rd_hs, last_rd;

  assign cfg_rd_valid = (st_q == LD_READ);
  assign cfg_rd_addr  = base_q + CAW'(wcnt_q);
  assign rd_hs        = cfg_rd_valid && cfg_rd_ready;
  assign last_rd      = rd_hs && (wcnt_q == len_q - LW'(1));
  assign fin          = ((st_q == LD_SETTLE) && (dcnt_q == DLAST)) || (NO_EXTRA && last_rd);

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    dcnt_d = dcnt_q;
    len_d  = len_q;
    base_d = base_q;
    case (st_q)
      LD_IDLE: if (start) begin
        st_d   = LD_READ;
        wcnt_d = '0;
        len_d  = len;
        base_d = CAW'(int'(mod_idx) * STRIDE);
      end
      LD_READ: if (rd_hs) begin
        if (last_rd) begin
          st_d   = NO_EXTRA ? LD_IDLE : LD_SETTLE;
          dcnt_d = '0;
        end else begin
          wcnt_d = wcnt_q + LW'(1);
        end
      end
      LD_SETTLE: begin
        if (dcnt_q == DLAST) st_d = LD_IDLE;
        else                 dcnt_d = dcnt_q + EW'(1);
      end
      default: st_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LD_IDLE;
      wcnt_q <= '0;
      dcnt_q <= '0;
      len_q  <= '0;
      base_q <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      dcnt_q <= dcnt_d;
      len_q  <= len_d;
      base_q <= base_d;
    end
  end

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_valid && !cfg_rd_ready) |=> (cfg_rd_valid && $stable(cfg_rd_addr)));
endmodule

// File: rtl/rsched_top.sv
module rsched_top
  import rsched_pkg::*;
#(
  parameter int NMOD        = 4,
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int DEPTH       = 4,
  parameter int LW          = 8,
  parameter int CAW         = 8,
  parameter int CFG_STRIDE  = 64,
  parameter int EXTRA_DELAY = 3,
  parameter logic [NMOD*LW-1:0] CFG_LEN = {8'd2, 8'd6, 8'd3, 8'd5},
  localparam int IW = (NMOD > 1) ? $clog2(NMOD) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_data,
  input  logic [NMOD-1:0] mod_busy,
  output logic           disp_valid,
  output logic [IW-1:0]  disp_mod,
  output logic [AW-1:0]  disp_addr,
  output logic [DW-1:0]  disp_data,
  output logic           cfg_rd_valid,
  input  logic           cfg_rd_ready,
  output logic [CAW-1:0] cfg_rd_addr,
  output logic           reconf_done,
  output logic [IW-1:0]  reconf_mod,
  output logic           busy
);
  localparam int QW = AW + DW;

  logic          rs_meta_q, rs_q;
  logic          head_valid, pop, start, fin, hit, region_free;
  logic [QW-1:0] head_data;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_pay;
  logic [IW-1:0] tgt;
  logic [LW-1:0] tgt_len;
  sch_state_t    st_q, st_d;
  logic          res_valid_q, res_valid_d;
  logic [IW-1:0] res_idx_q, res_idx_d;
  logic          disp_valid_q, done_q;
  logic [IW-1:0] disp_mod_q, done_mod_q;
  logic [AW-1:0] disp_addr_q;
  logic [DW-1:0] disp_data_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  rsched_fifo #(.W(QW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rs_q),
    .push_valid(req_valid), .push_ready(req_ready), .push_data({req_addr, req_data}),
    .pop(pop), .head_valid(head_valid), .head_data(head_data)
  );

  assign head_addr   = head_data[QW-1 -: AW];
  assign head_pay    = head_data[DW-1:0];
  assign tgt         = head_addr[AW-1 -: IW];
  assign tgt_len     = CFG_LEN[int'(tgt)*LW +: LW];
  assign hit         = res_valid_q && (res_idx_q == tgt);
  assign region_free = !res_valid_q || !mod_busy[res_idx_q];

  rsched_load #(.IW(IW), .LW(LW), .CAW(CAW), .STRIDE(CFG_STRIDE), .EXTRA(EXTRA_DELAY)) u_load (
    .clk(clk), .rst_n(rs_q), .start(start), .mod_idx(tgt), .len(tgt_len),
    .cfg_rd_valid(cfg_rd_valid), .cfg_rd_ready(cfg_rd_ready), .cfg_rd_addr(cfg_rd_addr),
    .fin(fin)
  );

  always_comb begin
    st_d        = st_q;
    pop         = 1'b0;
    start       = 1'b0;
    res_valid_d = res_valid_q;
    res_idx_d   = res_idx_q;
    case (st_q)
      SCH_IDLE: if (head_valid) begin
        if (hit) begin
          pop = 1'b1;
        end else if (region_free) begin
          start       = 1'b1;
          res_valid_d = 1'b0;
          st_d        = SCH_LOAD;
        end
      end
      SCH_LOAD: if (fin) begin
        res_valid_d = 1'b1;
        res_idx_d   = tgt;
        st_d        = SCH_IDLE;
      end
      default: st_d = SCH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      st_q         <= SCH_IDLE;
      res_valid_q  <= 1'b0;
      res_idx_q    <= '0;
      disp_valid_q <= 1'b0;
      done_q       <= 1'b0;
      done_mod_q   <= '0;
    end else begin
      st_q         <= st_d;
      res_valid_q  <= res_valid_d;
      res_idx_q    <= res_idx_d;
      disp_valid_q <= pop;
      done_q       <= fin;
      if (fin) done_mod_q <= tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) begin
      disp_mod_q  <= tgt;
      disp_addr_q <= head_addr;
      disp_data_q <= head_pay;
    end
  end

  assign disp_valid  = disp_valid_q;
  assign disp_mod    = disp_mod_q;
  assign disp_addr   = disp_addr_q;
  assign disp_data   = disp_data_q;
  assign reconf_done = done_q;
  assign reconf_mod  = done_mod_q;
  assign busy        = head_valid || (st_q == SCH_LOAD);

  // R6
  disp_resident_chk: assert property (@(posedge clk) disable iff (!rs_q)
    disp_valid_q |-> (res_valid_q && res_idx_q == disp_mod_q));
  // R7
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rs_q)
    (res_valid_q && mod_busy[res_idx_q]) |-> !cfg_rd_valid);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rs_q)
    done_q |=> !done_q);
endmodule

// File: tb/sim_rsched_top.sv
module sim_rsched_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_data = '0;
  logic [3:0]  mod_busy = '0;
  logic        disp_valid;
  logic [1:0]  disp_mod;
  logic [7:0]  disp_addr;
  logic [15:0] disp_data;
  logic        cfg_rd_valid;
  logic        cfg_rd_ready = 1'b1;
  logic [7:0]  cfg_rd_addr;
  logic        reconf_done;
  logic [1:0]  reconf_mod;
  logic        busy;

  int errors = 0, checks = 0, cyc = 0;
  bit stall_en = 1'b0;

  int nd = 0, ndn = 0, nr = 0;
  logic [1:0]  dlog_mod [64];
  logic [15:0] dlog_data [64];
  logic [7:0]  dlog_addr [64];
  int          dlog_cyc [64];
  logic [1:0]  nlog_mod [64];
  int          nlog_cyc [64];
  logic [7:0]  rlog_addr [64];
  int          rlog_cyc [64];

  rsched_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .mod_busy(mod_busy),
    .disp_valid(disp_valid), .disp_mod(disp_mod), .disp_addr(disp_addr), .disp_data(disp_data),
    .cfg_rd_valid(cfg_rd_valid), .cfg_rd_ready(cfg_rd_ready), .cfg_rd_addr(cfg_rd_addr),
    .reconf_done(reconf_done), .reconf_mod(reconf_mod), .busy(busy)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (disp_valid && nd < 64) begin
      dlog_mod[nd] = disp_mod; dlog_data[nd] = disp_data;
      dlog_addr[nd] = disp_addr; dlog_cyc[nd] = cyc; nd = nd + 1;
    end
    if (reconf_done && ndn < 64) begin
      nlog_mod[ndn] = reconf_mod; nlog_cyc[ndn] = cyc; ndn = ndn + 1;
    end
    if (cfg_rd_valid && cfg_rd_ready && nr < 64) begin
      rlog_addr[nr] = cfg_rd_addr; rlog_cyc[nr] = cyc; nr = nr + 1;
    end
    cfg_rd_ready = stall_en ? cyc[0] : 1'b1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_logs();
    nd = 0; ndn = 0; nr = 0;
  endtask

  task automatic send(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_disp(input int n);
    for (int i = 0; i < 500 && nd < n; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
    check(busy == 1'b0, "R10 busy after reset", busy, 0);
    check(cfg_rd_valid == 1'b0 && disp_valid == 1'b0 && reconf_done == 1'b0,
          "R2 idle outputs after reset", cfg_rd_valid, 0);
  endtask

  task automatic t_first_load();
    clr_logs();
    send(8'h45, 16'h1234);
    @(negedge clk);
    check(busy == 1'b1, "R10 busy during load", busy, 1);
    wait_disp(1);
    check(nr == 3, "R2 R4 read count mod1", nr, 3);
    for (int i = 0; i < 3 && i < nr; i++)
      check(rlog_addr[i] == 8'(64 + i), "R4 read address mod1", rlog_addr[i], 64 + i);
    check(ndn == 1 && nlog_mod[0] == 2'd1, "R5 done index mod1", nlog_mod[0], 1);
    check(nlog_cyc[0] - rlog_cyc[0] == 6, "R5 load latency mod1", nlog_cyc[0] - rlog_cyc[0], 6);
    check(nd == 1 && dlog_cyc[0] == nlog_cyc[0] + 1, "R6 dispatch after done", dlog_cyc[0], nlog_cyc[0] + 1);
    check(dlog_mod[0] == 2'd1 && dlog_addr[0] == 8'h45 && dlog_data[0] == 16'h1234,
          "R1 dispatch fields", dlog_data[0], 16'h1234);
    check(busy == 1'b0, "R10 busy cleared", busy, 0);
  endtask

  task automatic t_hit();
    clr_logs();
    send(8'h7F, 16'h5555);
    wait_disp(1);
    check(nr == 0 && ndn == 0, "R3 no load on hit", nr, 0);
    check(nd == 1 && dlog_mod[0] == 2'd1 && dlog_data[0] == 16'h5555, "R3 R1 hit dispatch", dlog_data[0], 16'h5555);
  endtask

  task automatic t_no_preempt();
    clr_logs();
    mod_busy = 4'b0010;
    send(8'h80, 16'h0222);
    repeat (20) @(negedge clk);
    check(nr == 0 && nd == 0, "R7 no load while resident busy", nr, 0);
    check(busy == 1'b1, "R10 busy while request held", busy, 1);
    mod_busy = 4'b0000;
    wait_disp(1);
    check(nr == 6 && rlog_addr[0] == 8'd128 && rlog_addr[5] == 8'd133, "R4 mod2 reads", nr, 6);
    check(ndn == 1 && nlog_mod[0] == 2'd2, "R5 done index mod2", nlog_mod[0], 2);
    check(nd == 1 && dlog_mod[0] == 2'd2 && dlog_data[0] == 16'h0222, "R7 R1 dispatch after release", dlog_data[0], 16'h0222);
  endtask

  task automatic t_evict_stall();
    clr_logs();
    stall_en = 1'b1;
    send(8'h40, 16'h0111);
    wait_disp(1);
    stall_en = 1'b0;
    check(nr == 3, "R8 evicted module reloaded", nr, 3);
    for (int i = 0; i < 3 && i < nr; i++)
      check(rlog_addr[i] == 8'(64 + i), "R4 stalled read address", rlog_addr[i], 64 + i);
    check(ndn == 1 && nlog_mod[0] == 2'd1 && nlog_cyc[0] - rlog_cyc[0] >= 6, "R5 R8 reload done", nlog_cyc[0] - rlog_cyc[0], 6);
    check(nd == 1 && dlog_cyc[0] == nlog_cyc[0] + 1, "R6 dispatch after stalled load", dlog_cyc[0], nlog_cyc[0] + 1);
  endtask

  task automatic t_backpressure();
    logic [7:0] addrs [6];
    addrs = '{8'h10, 8'hC3, 8'h11, 8'hC4, 8'h12, 8'hC5};
    clr_logs();
    mod_busy = 4'b0010;
    fork
      begin
        for (int i = 0; i < 6; i++) send(addrs[i], 16'(16'hA0 + i));
      end
      begin
        repeat (30) @(negedge clk);
        check(req_ready == 1'b0, "R9 ready low when full", req_ready, 0);
        check(nd == 0 && nr == 0, "R7 R9 nothing moves while blocked", nd, 0);
        mod_busy = 4'b0000;
      end
    join
    wait_disp(6);
    check(nd == 6, "R9 no request dropped", nd, 6);
    for (int i = 0; i < 6 && i < nd; i++) begin
      check(dlog_data[i] == 16'(16'hA0 + i), "R9 dispatch order", dlog_data[i], 16'hA0 + i);
      check(dlog_mod[i] == addrs[i][7:6], "R1 decoded module", dlog_mod[i], addrs[i][7:6]);
    end
    check(ndn == 6, "R8 alternating targets reload each time", ndn, 6);
    for (int i = 0; i < 6 && i < ndn; i++)
      check(nlog_mod[i] == ((i % 2 == 0) ? 2'd0 : 2'd3), "R8 load order", nlog_mod[i], (i % 2 == 0) ? 0 : 3);
    check(busy == 1'b0, "R10 idle at end", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first_load();
    t_hit();
    t_no_preempt();
    t_evict_stall();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule